// File: doc/BRIEF.md
# Divergent Branch Lane Mask Stack

This block holds the active-lane mask for a 32-lane SIMD processor that runs threads in lockstep. Each lane computes every instruction. Only lanes whose active bit is set commit their results. When a branch splits the lanes, the control path issues three commands in order. The push command saves the current mask and narrows the mask to the lanes whose predicate bit takes the then path. The complement command flips the mask to the else lanes within the saved parent. The pop command restores the saved parent at the reconvergence point.

Masks are kept on a hardware LIFO of lane masks, so if/else regions can be nested. A push whose new mask is empty raises a one-cycle skip indication, so the sequencer can bypass the then path. An empty flag and two sticky error flags let the control path see the state of the stack. The overflow flag reports a push onto a full stack, and the underflow flag reports a pop from an empty one.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the empty flag is 1, and skip, overflow and underflow are 0.
- R2: A push on a stack that is not full saves the current mask on the stack. From the next cycle the active mask equals the old mask ANDed with the predicate vector, and the empty flag is 0.
- R3: The skip output is 1 for exactly the one cycle after a push that succeeded and produced an all-zero mask. In every other cycle it is 0.
- R4: A complement sets the active mask to the inverse of the current mask ANDed with the top stack entry, and leaves the stack unchanged. When the stack is empty, all ones is used in place of the top entry.
- R5: A pop on a stack that is not empty restores the most recently saved mask and removes that entry. Nested regions therefore unwind in LIFO order, and the empty flag returns to 1 when the last entry is removed.
- R6: A pop on an empty stack sets the active mask to all ones and sets a sticky underflow flag, which stays at 1 until reset.
- R7: The stack holds DEPTH entries (8 by default). A push onto a full stack leaves both the stack and the active mask unchanged, and sets a sticky overflow flag, which stays at 1 until reset.
- R8: When several commands are asserted in the same cycle, push takes priority over complement, and complement takes priority over pop. With no command asserted, the mask and the stack hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_i | input | LANES | Per-lane branch predicate, 1 = takes the then path |
| push_i | input | 1 | Divergent branch: save the mask and narrow it |
| comp_i | input | 1 | Switch to the else lanes |
| pop_i | input | 1 | Reconverge: restore the saved mask |
| active_o | output | LANES | Active lane mask that gates commits |
| skip_o | output | 1 | Pulse: the pushed mask has no lanes |
| empty_o | output | 1 | The stack holds no entries |
| overflow_o | output | 1 | Sticky: a push arrived on a full stack |
| underflow_o | output | 1 | Sticky: a pop arrived on an empty stack |

## Verification
The assertions that check the result of a single command state that command's priority in their guard, so they still hold when commands overlap. The assertions take the stack occupancy as correctly counted, and use it only to decide whether a push or a pop is legal. The stimulus is mostly one command at a time. It drives pushes past the full point and pops past the empty point on purpose, and includes a few cycles with overlapping commands to exercise the priority order. Predicates are biased toward all-zero and all-one vectors, so that the skip and full-mask cases occur often.

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pred_i,
  input  logic             push_i,
  input  logic             comp_i,
  input  logic             pop_i,
  output logic [LANES-1:0] active_o,
  output logic             skip_o,
  output logic             empty_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [LANES-1:0] stk [DEPTH];
  logic [LANES-1:0] act_q;
  logic [CW-1:0]    sp;
  logic             skip_q, ovf_q, unf_q;

  wire              full    = (sp == CW'(DEPTH));
  wire              empty   = (sp == '0);
  wire [AW-1:0]     wr_idx  = AW'(sp);
  wire [AW-1:0]     top_idx = AW'(sp - 1'b1);
  wire [LANES-1:0]  parent  = empty ? '1 : stk[top_idx];
  wire [LANES-1:0]  narrow  = act_q & pred_i;
  wire              do_push = push_i && !full;
  wire              do_comp = !push_i && comp_i;
  wire              do_pop  = !push_i && !comp_i && pop_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '1;
      sp     <= '0;
      skip_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      skip_q <= do_push && (narrow == '0);
      if (push_i && full) ovf_q <= 1'b1;
      if (do_push) begin
        sp    <= sp + 1'b1;
        act_q <= narrow;
      end else if (do_comp) begin
        act_q <= ~act_q & parent;
      end else if (do_pop) begin
        if (empty) begin
          act_q <= '1;
          unf_q <= 1'b1;
        end else begin
          act_q <= stk[top_idx];
          sp    <= sp - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) stk[wr_idx] <= act_q;
  end

  assign active_o    = act_q;
  assign skip_o      = skip_q;
  assign empty_o     = empty;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;
endmodule

module lane_mask_stack_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] pred_i,
  input logic             push_i,
  input logic             comp_i,
  input logic             pop_i,
  input logic [LANES-1:0] active_o,
  input logic             skip_o,
  input logic             empty_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic [$clog2(DEPTH+1)-1:0] sp
);
  wire full = (sp == ($clog2(DEPTH+1))'(DEPTH));

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (active_o == '1) && empty_o && !skip_o && !overflow_o && !underflow_o);

  a_r2_push_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full) |=> (active_o == $past(active_o & pred_i)) && !empty_o);

  a_r3_skip_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (active_o == '0));

  a_r4_comp_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && comp_i) |=> ((active_o & $past(active_o)) == '0) && $stable(empty_o));

  a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !comp_i && pop_i && empty_o) |=> (active_o == '1) && underflow_o);

  a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  a_r7_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full) |=> overflow_o && $stable(active_o));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !comp_i && !pop_i) |=> $stable(active_o) && $stable(empty_o));
endmodule

bind lane_mask_stack lane_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_i(pred_i), .push_i(push_i), .comp_i(comp_i),
  .pop_i(pop_i), .active_o(active_o), .skip_o(skip_o), .empty_o(empty_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .sp(sp)
);

// File: tb/lane_mask_stack_tb.sv
`timescale 1ns/1ps
module lane_mask_stack_tb;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] pred_i = '0;
  logic push_i = 1'b0, comp_i = 1'b0, pop_i = 1'b0;
  logic [LANES-1:0] active_o;
  logic skip_o, empty_o, overflow_o, underflow_o;

  int total = 0;
  int bad = 0;

  logic [LANES-1:0] m_stk [DEPTH];
  logic [LANES-1:0] m_act;
  int               m_sp;
  logic             m_skip, m_ovf, m_unf;

  always #4 clk = ~clk;

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_i(pred_i), .push_i(push_i), .comp_i(comp_i),
    .pop_i(pop_i), .active_o(active_o), .skip_o(skip_o), .empty_o(empty_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  function automatic logic [LANES-1:0] f_parent();
    return (m_sp == 0) ? '1 : m_stk[m_sp-1];
  endfunction

  task automatic model_reset();
    m_act = '1; m_sp = 0; m_skip = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic model_step(input logic p, input logic c, input logic o, input logic [LANES-1:0] pr);
    logic [LANES-1:0] nm;
    nm = m_act & pr;
    m_skip = 0;
    if (p) begin
      if (m_sp == DEPTH) m_ovf = 1;
      else begin
        m_stk[m_sp] = m_act; m_sp++; m_act = nm; m_skip = (nm == '0);
      end
    end else if (c) begin
      m_act = ~m_act & f_parent();
    end else if (o) begin
      if (m_sp == 0) begin m_act = '1; m_unf = 1; end
      else begin m_sp--; m_act = m_stk[m_sp]; end
    end
  endtask

  task automatic chk(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R2 R4 R5 R8 active", active_o, m_act);
    chk("R1 R5 empty", LANES'(empty_o), LANES'(m_sp == 0));
    chk("R3 skip", LANES'(skip_o), LANES'(m_skip));
    chk("R7 overflow", LANES'(overflow_o), LANES'(m_ovf));
    chk("R6 underflow", LANES'(underflow_o), LANES'(m_unf));
  endtask

  task automatic cyc(input logic p, input logic c, input logic o, input logic [LANES-1:0] pr);
    push_i = p; comp_i = c; pop_i = o; pred_i = pr;
    model_step(p, c, o, pr);
    @(posedge clk);
    @(negedge clk);
    chk_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push_i = 0; comp_i = 0; pop_i = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk_all();
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    logic [LANES-1:0] pr;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R1 explicit
    chk("R1 reset mask", active_o, '1);
    // nested if/else: R2, R4, R5
    cyc(1, 0, 0, 32'h0000_FFFF);
    cyc(1, 0, 0, 32'h00FF_00FF);
    cyc(0, 1, 0, '0);
    chk("R4 else lanes", active_o, 32'h0000_FF00);
    cyc(0, 0, 1, '0);
    chk("R5 restore inner", active_o, 32'h0000_FFFF);
    cyc(0, 1, 0, '0);
    cyc(0, 0, 1, '0);
    chk("R5 restore outer", active_o, '1);
    // R3 skip
    cyc(1, 0, 0, '0);
    chk("R3 skip pulse", LANES'(skip_o), 1);
    cyc(0, 0, 0, '0);
    chk("R3 skip one cycle", LANES'(skip_o), 0);
    cyc(0, 0, 1, '0);
    // R7 overflow
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 0, 0, ~(32'h1 << i));
    chk("R7 overflow set", LANES'(overflow_o), 1);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, '0);
    chk("R7 stack intact", active_o, '1);
    // R6 underflow
    cyc(1, 0, 0, 32'h1234_5678);
    cyc(0, 1, 0, '0);
    cyc(0, 0, 1, '0);
    cyc(0, 0, 1, '0);
    chk("R6 underflow set", LANES'(underflow_o), 1);
    // R8 priority
    do_reset();
    cyc(1, 1, 1, 32'hF0F0_F0F0);
    chk("R8 push wins", active_o, 32'hF0F0_F0F0);
    cyc(0, 1, 1, '0);
    chk("R8 comp beats pop", active_o, 32'h0F0F_0F0F);
    cyc(0, 1, 0, '0);
    // random
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom_range(0, 99));
      case ($urandom_range(0, 3))
        0: pr = '0;
        1: pr = '1;
        default: pr = $urandom();
      endcase
      if (r < 30)      cyc(1, 0, 0, pr);
      else if (r < 50) cyc(0, 1, 0, pr);
      else if (r < 78) cyc(0, 0, 1, pr);
      else if (r < 93) cyc(0, 0, 0, pr);
      else             cyc(1'($urandom()), 1'($urandom()), 1'($urandom()), pr);
      if (n % 1000 == 999) do_reset();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule